// File: doc/BRIEF.md
# Configurable DRAM Access Sequencer

This block turns simple single-word requests from inside the chip into strobe sequences for an asynchronous DRAM: a row strobe (`ras_n`), a column strobe (`cas_n`), a write strobe (`we_n`) and a time-shared address bus that carries first the row and then the column. A requester raises `req` with an address, a write flag and write data. It holds them until `req_ready` pulses and then takes the read data from `req_rdata`. Between accesses the sequencer also runs refresh cycles of the CAS-before-RAS kind, requested by a periodic `rfsh_tick`.

Its timing is set at run time by an 8-bit control register written through `cfg_we`/`cfg_wdata` and read back on `cfg_rdata`. The fields are: [7] precharge length, [6] page-mode bursts, [5] keep the row open while idle, [4] refresh CAS lead, [3:2] row/column split, [1:0] refresh wait states. With bursts on, the sequencer keeps the last row open. A later request to the same row then only toggles CAS. A request to another row, or a refresh, first closes the row and precharges.

Top module: `dram_seq_top`

## Requirements
- R1: `cfg_rdata` returns the last byte written. The register reads 0x00 after `por_n` is low and one clock after `hw_stby` is high.
- R2: A one-cycle `soft_rst` returns the sequencer to idle and leaves the register contents unchanged.
- R3: Bit 7 sets the precharge time: RAS stays high for 1 cycle (bit 7 = 0) or 2 cycles (bit 7 = 1) after it rises, before it may fall again.
- R4: With bit 6 = 0, every access runs a full cycle: one RAS-only state with the row address, one CAS-low state with the column address, then one completion state with `req_ready`. From idle, `req_ready` is seen after the third clock edge. A request held back-to-back after a completion sees `req_ready` 5 + bit7 edges after the previous one.
- R5: With bit 6 = 1, the row stays open after an access. A request to the same row gets `req_ready` 3 edges after the previous completion, or 2 edges when it arrives while the row sits open. A request to a different row takes 6 + bit7 edges.
- R6: With bit 6 = 1, an open row with no request is closed at once when bit 5 = 0, and is held with `ras_n` low indefinitely when bit 5 = 1.
- R7: Field [3:2] = s places the row at address bits above 8 + s, driven on `mem_addr` while RAS falls. The column is the low 8 + s bits, driven while CAS is low.
- R8: A refresh holds CAS low with RAS high for 1 + bit4 cycles, then holds both low for 1 + field[1:0] cycles, then precharges as in R3.
- R9: A refresh tick arriving with, or before, a request is served first. A pending refresh closes an open row, so the next access starts from idle.
- R10: `req_ready` is high for exactly one cycle per access. With it, `req_rdata` holds the word sampled at the end of the CAS-low state. A write drives `mem_dq_out` with `mem_dq_oe` high and `we_n` low during CAS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| hw_stby | input | 1 | Hardware standby: clears register and sequencer |
| soft_rst | input | 1 | Manual reset: clears sequencer, keeps register |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register contents |
| req | input | 1 | Access request, held until `req_ready` |
| req_addr | input | AW | Word address |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DW | Write data |
| req_ready | output | 1 | One-cycle completion pulse |
| req_rdata | output | DW | Read data, valid with `req_ready` |
| rfsh_tick | input | 1 | Refresh request pulse |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write strobe, active low |
| mem_addr | output | MA | Multiplexed row/column address |
| mem_dq_out | output | DW | Data driven to memory |
| mem_dq_oe | output | 1 | Data output enable |
| mem_dq_in | input | DW | Data returned from memory |

## Verification
Each pair of back-to-back accesses is run against a behavioural memory that rebuilds the word address from the strobes and the shared address bus. Three kinds of pair are used: same address, same row but a different column, and a different row. Repeating these pairs across every precharge length, burst setting and split width separates the full-cycle, page-hit and row-miss latencies. A corrupted read or write shows that the row/column split is wrong. Directed cases also hold a request against a simultaneous refresh tick, refresh while a row is open, and idle with and without the row-hold bit. These cases expose priority errors and rows that are wrongly kept or dropped.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ROW, ST_COL, ST_CEND, ST_OPEN, ST_PRE, ST_RFC, ST_RFR
  } seq_st_e;

  // Control register layout, bit 7 first
  typedef struct packed {
    logic       tpc;       // [7] two precharge states
    logic       burst;     // [6] page-mode bursts
    logic       ras_hold;  // [5] hold row open while idle
    logic       rf_lead;   // [4] extra CAS lead in refresh
    logic [1:0] shift;     // [3:2] row split at 8+shift
    logic [1:0] rf_wait;   // [1:0] refresh wait states
  } cfg_t;

  function automatic int unsigned split_bits(logic [1:0] s);
    return 32'd8 + 32'(s);
  endfunction

  function automatic logic [31:0] row_of(logic [31:0] a, logic [1:0] s);
    return a >> split_bits(s);
  endfunction

  function automatic logic [31:0] col_of(logic [31:0] a, logic [1:0] s);
    return a & ((32'd1 << split_bits(s)) - 32'd1);
  endfunction

endpackage

// File: rtl/dram_cfg_reg.sv
module dram_cfg_reg
  import dram_seq_pkg::*;
(
  input  logic       clk,
  input  logic       por_n,
  input  logic       hw_stby,
  input  logic       soft_rst,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output cfg_t       cfg,
  output logic [7:0] rdata
);
  logic [7:0] cfg_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)       cfg_q <= 8'h00;
    else if (hw_stby) cfg_q <= 8'h00;
    else if (wr_en)   cfg_q <= wdata;
  end

  assign cfg   = cfg_t'(cfg_q);
  assign rdata = cfg_q;

  assert_stby_clear_R1: assert property (@(posedge clk) disable iff (!por_n)
    hw_stby |=> (rdata == 8'h00))
    else $error("standby did not clear control register");

  assert_soft_keep_R2: assert property (@(posedge clk) disable iff (!por_n)
    (soft_rst && !wr_en && !hw_stby) |=> (rdata == $past(rdata)))
    else $error("manual reset altered control register");

endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux
  import dram_seq_pkg::*;
#(
  parameter int AW = 12,
  parameter int MA = 11
) (
  input  logic [AW-1:0] addr,
  input  logic [1:0]    shift,
  input  logic          sel_col,
  output logic [MA-1:0] mux_addr
);
  logic [31:0] part;

  assign part = sel_col ? col_of(32'(addr), shift) : row_of(32'(addr), shift);

  generate
    if (MA <= 32) begin : g_slice
      assign mux_addr = part[MA-1:0];
    end else begin : g_ext
      assign mux_addr = {{(MA-32){1'b0}}, part};
    end
  endgenerate

endmodule

// File: rtl/dram_seq_fsm.sv
module dram_seq_fsm
  import dram_seq_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          sync_clr,
  input  cfg_t          cfg,
  input  logic          req,
  input  logic [AW-1:0] req_addr,
  input  logic          req_we,
  input  logic          rfsh_tick,
  output logic          accept,
  output logic          ras_n,
  output logic          cas_n,
  output logic          we_n,
  output logic          sel_col,
  output logic          ready,
  output logic          cap_en
);
  seq_st_e       state, nxt;
  logic [1:0]    cnt, cnt_nxt;
  logic          pend, we_q;
  logic [AW-1:0] open_row, row_now;
  logic          rf_want, enter_rf, row_hit;

  assign row_now  = AW'(row_of(32'(req_addr), cfg.shift));
  assign row_hit  = (row_now == open_row);
  assign rf_want  = pend | rfsh_tick;
  assign enter_rf = (state == ST_IDLE) && rf_want;

  always_comb begin
    nxt     = state;
    cnt_nxt = cnt;
    accept  = 1'b0;
    case (state)
      ST_IDLE: begin
        cnt_nxt = 2'd0;
        if (rf_want) nxt = ST_RFC;
        else if (req) begin
          nxt    = ST_ROW;
          accept = 1'b1;
        end
      end
      ST_ROW:  nxt = ST_COL;
      ST_COL:  nxt = ST_CEND;
      ST_CEND: begin
        cnt_nxt = 2'd0;
        nxt     = cfg.burst ? ST_OPEN : ST_PRE;
      end
      ST_OPEN: begin
        cnt_nxt = 2'd0;
        if (rf_want) nxt = ST_PRE;
        else if (req && row_hit) begin
          nxt    = ST_COL;
          accept = 1'b1;
        end else if (req || !cfg.ras_hold) nxt = ST_PRE;
      end
      ST_PRE: begin
        if (cnt == {1'b0, cfg.tpc}) begin
          nxt     = ST_IDLE;
          cnt_nxt = 2'd0;
        end else cnt_nxt = cnt + 2'd1;
      end
      ST_RFC: begin
        if (cnt == {1'b0, cfg.rf_lead}) begin
          nxt     = ST_RFR;
          cnt_nxt = 2'd0;
        end else cnt_nxt = cnt + 2'd1;
      end
      ST_RFR: begin
        if (cnt == cfg.rf_wait) begin
          nxt     = ST_PRE;
          cnt_nxt = 2'd0;
        end else cnt_nxt = cnt + 2'd1;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      state    <= ST_IDLE;
      cnt      <= 2'd0;
      pend     <= 1'b0;
      we_q     <= 1'b0;
      open_row <= '0;
    end else if (sync_clr) begin
      state <= ST_IDLE;
      cnt   <= 2'd0;
      pend  <= 1'b0;
    end else begin
      state <= nxt;
      cnt   <= cnt_nxt;
      pend  <= rf_want && !enter_rf;
      if (accept) begin
        open_row <= row_now;
        we_q     <= req_we;
      end
    end
  end

  always_comb begin
    ras_n   = 1'b1;
    cas_n   = 1'b1;
    sel_col = 1'b0;
    case (state)
      ST_ROW:  ras_n = 1'b0;
      ST_COL:  begin ras_n = 1'b0; cas_n = 1'b0; sel_col = 1'b1; end
      ST_CEND: ras_n = 1'b0;
      ST_OPEN: ras_n = 1'b0;
      ST_RFC:  cas_n = 1'b0;
      ST_RFR:  begin ras_n = 1'b0; cas_n = 1'b0; end
      default: ;
    endcase
  end

  assign we_n   = !((state == ST_COL) && we_q);
  assign ready  = (state == ST_CEND);
  assign cap_en = (state == ST_COL) && !we_q;

  assert_pre_min_R3: assert property (@(posedge clk) disable iff (!por_n)
    $rose(ras_n) |=> ras_n)
    else $error("RAS reopened without precharge");

  assert_pre_two_R3: assert property (@(posedge clk) disable iff (!por_n)
    ($rose(ras_n) && cfg.tpc) |=> (ras_n ##1 ras_n))
    else $error("two-state precharge cut short");

  assert_cbr_hold_R8: assert property (@(posedge clk) disable iff (!por_n)
    (!cas_n && ras_n && !sync_clr) |=> !cas_n)
    else $error("CAS released before RAS in refresh");

  assert_ready_pulse_R10: assert property (@(posedge clk) disable iff (!por_n)
    ready |=> !ready)
    else $error("ready longer than one cycle");

  assert_write_in_col_R10: assert property (@(posedge clk) disable iff (!por_n)
    !we_n |-> (!cas_n && !ras_n))
    else $error("write strobe outside column state");

endmodule

// File: rtl/dram_seq_top.sv
module dram_seq_top
  import dram_seq_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 16,
  parameter int MA = 11
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          hw_stby,
  input  logic          soft_rst,
  input  logic          cfg_we,
  input  logic [7:0]    cfg_wdata,
  output logic [7:0]    cfg_rdata,
  input  logic          req,
  input  logic [AW-1:0] req_addr,
  input  logic          req_we,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic [DW-1:0] req_rdata,
  input  logic          rfsh_tick,
  output logic          ras_n,
  output logic          cas_n,
  output logic          we_n,
  output logic [MA-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);
  cfg_t          cfg;
  logic          accept, sel_col, cap_en, sync_clr;
  logic [AW-1:0] lat_addr;
  logic [DW-1:0] lat_wdata, rdata_q;

  assign sync_clr = soft_rst | hw_stby;

  dram_cfg_reg u_cfg (
    .clk(clk), .por_n(por_n), .hw_stby(hw_stby), .soft_rst(soft_rst),
    .wr_en(cfg_we), .wdata(cfg_wdata), .cfg(cfg), .rdata(cfg_rdata)
  );

  dram_seq_fsm #(.AW(AW)) u_fsm (
    .clk(clk), .por_n(por_n), .sync_clr(sync_clr), .cfg(cfg),
    .req(req), .req_addr(req_addr), .req_we(req_we), .rfsh_tick(rfsh_tick),
    .accept(accept), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .sel_col(sel_col), .ready(req_ready), .cap_en(cap_en)
  );

  dram_addr_mux #(.AW(AW), .MA(MA)) u_mux (
    .addr(lat_addr), .shift(cfg.shift), .sel_col(sel_col), .mux_addr(mem_addr)
  );

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      lat_addr  <= '0;
      lat_wdata <= '0;
      rdata_q   <= '0;
    end else begin
      if (accept) begin
        lat_addr  <= req_addr;
        lat_wdata <= req_wdata;
      end
      if (cap_en) rdata_q <= mem_dq_in;
    end
  end

  assign req_rdata  = rdata_q;
  assign mem_dq_out = lat_wdata;
  assign mem_dq_oe  = !we_n;

endmodule

// File: tb/tb_dram_seq_top.sv
`timescale 1ns/1ps
module tb_dram_seq_top;
  localparam int AW = 12;
  localparam int DW = 16;
  localparam int MA = 11;

  logic clk = 1'b0;
  logic por_n, hw_stby, soft_rst, cfg_we, req, req_we, rfsh_tick;
  logic [7:0] cfg_wdata, cfg_rdata;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata, req_rdata, mem_dq_out, mem_dq_in;
  logic req_ready, ras_n, cas_n, we_n, mem_dq_oe;
  logic [MA-1:0] mem_addr;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dram_seq_top #(.AW(AW), .DW(DW), .MA(MA)) dut (
    .clk(clk), .por_n(por_n), .hw_stby(hw_stby), .soft_rst(soft_rst),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .req(req), .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata),
    .req_ready(req_ready), .req_rdata(req_rdata), .rfsh_tick(rfsh_tick),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .mem_addr(mem_addr),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  // ---------------- behavioural memory ----------------
  logic [7:0]  cur_cfg = 8'h00;
  logic [DW-1:0] mem [0:(1<<AW)-1];
  logic [MA-1:0] m_row = '0;
  logic prev_ras = 1'b1;
  logic cbr = 1'b0;
  int cbr_cnt = 0, lead_cnt = 0, rlow_cnt = 0;

  function automatic logic [AW-1:0] word_addr(logic [MA-1:0] r, logic [MA-1:0] c, logic [1:0] s);
    int sp;
    sp = 8 + int'(s);
    return AW'((32'(r) << sp) | (32'(c) & ((32'd1 << sp) - 32'd1)));
  endfunction

  assign mem_dq_in = mem[word_addr(m_row, mem_addr, cur_cfg[3:2])];

  always @(negedge clk) begin
    logic cbr_now;
    if (!por_n) begin
      prev_ras = 1'b1;
      cbr = 1'b0;
    end else begin
      cbr_now = (!ras_n && prev_ras) ? !cas_n : cbr;
      if (!ras_n && prev_ras) begin
        m_row = mem_addr;
        cbr = !cas_n;
        if (!cas_n) cbr_cnt++;
      end
      if (!cas_n && ras_n) lead_cnt++;
      if (!ras_n && cbr_now) rlow_cnt++;
      if (!ras_n && !cas_n && mem_dq_oe && !cbr_now)
        mem[word_addr(m_row, mem_addr, cur_cfg[3:2])] = mem_dq_out;
      prev_ras = ras_n;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic wr_cfg(input logic [7:0] v);
    cfg_we = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    cur_cfg = v;
  endtask

  // called at a negedge; returns at the negedge where ready is seen
  task automatic access(input logic [AW-1:0] a, input logic w, input logic [DW-1:0] d,
                        input bit tick, output int lat, output logic [DW-1:0] rd);
    req = 1'b1; req_addr = a; req_we = w; req_wdata = d;
    rfsh_tick = tick;
    lat = 0;
    forever begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      rfsh_tick = 1'b0;
      if (req_ready || lat > 60) break;
    end
    rd = req_rdata;
    req = 1'b0;
  endtask

  task automatic clr_counts();
    cbr_cnt = 0; lead_cnt = 0; rlow_cnt = 0;
  endtask

  // {pad, cfg, a1(16), a2(16), write2(8), latency2(8)}
  localparam logic [63:0] VEC [10] = '{
    64'h00_00_0123_0123_00_05,
    64'h00_80_02A5_02A5_00_06,
    64'h00_40_0312_03F0_00_03,
    64'h00_40_0312_0412_00_06,
    64'h00_C0_0100_0200_00_07,
    64'h00_64_0210_03FF_00_03,
    64'h00_44_01FF_0200_00_06,
    64'h00_4C_0005_07FE_00_03,
    64'h00_48_03FF_0400_00_06,
    64'h00_40_0055_0066_01_03
  };

  initial begin
    #(8 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired R10 actual=hung expected=done");
    finish_run();
  end

  initial begin
    int lat;
    logic [DW-1:0] rd, d1, d2, expd;
    logic [63:0] v;
    logic [AW-1:0] a1, a2;

    for (int k = 0; k < (1 << AW); k++) mem[k] = DW'(k) ^ 16'h3C3C;
    por_n = 1'b0; hw_stby = 1'b0; soft_rst = 1'b0; cfg_we = 1'b0; cfg_wdata = 8'h00;
    req = 1'b0; req_addr = '0; req_we = 1'b0; req_wdata = '0; rfsh_tick = 1'b0;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);

    // reset state (R1)
    chk(cfg_rdata == 8'h00, "R1 reset value", 32'(cfg_rdata), 0);
    chk(ras_n && cas_n && we_n && !req_ready, "R1 idle strobes after reset",
        {ras_n, cas_n, we_n, req_ready}, 4'b1110);

    // table of access pairs
    for (int i = 0; i < 10; i++) begin
      v  = VEC[i];
      a1 = v[43:32];
      a2 = v[27:16];
      wr_cfg(8'h00);
      repeat (8) @(negedge clk);
      wr_cfg(v[55:48]);
      chk(cfg_rdata == v[55:48], "R1 readback", 32'(cfg_rdata), 32'(v[55:48]));
      d1 = 16'hA000 + DW'(i) * 16'h0111;
      d2 = 16'h5000 + DW'(i);
      access(a1, 1'b1, d1, 1'b0, lat, rd);
      chk(lat == 3, "R4 latency from idle", 32'(lat), 3);
      access(a2, v[8], d2, 1'b0, lat, rd);
      chk(lat == int'(v[7:0]), "R3/R4/R5 back-to-back latency", 32'(lat), 32'(v[7:0]));
      if (!v[8]) begin
        expd = (a2 == a1) ? d1 : (DW'(a2) ^ 16'h3C3C);
        chk(rd == expd, "R7/R10 read data", 32'(rd), 32'(expd));
      end else begin
        chk(mem[a2] == d2, "R7 second write landed", 32'(mem[a2]), 32'(d2));
        chk(mem[a1] == d1, "R7 first write landed", 32'(mem[a1]), 32'(d1));
      end
    end

    // ready is one cycle (R10)
    wr_cfg(8'h00);
    repeat (6) @(negedge clk);
    access(12'h0ABC, 1'b0, '0, 1'b0, lat, rd);
    @(negedge clk);
    chk(!req_ready, "R10 ready single cycle", 32'(req_ready), 0);

    // row held in idle, page hit later (R6, R5)
    wr_cfg(8'h60);
    repeat (4) @(negedge clk);
    access(12'h123, 1'b1, 16'h7777, 1'b0, lat, rd);
    repeat (6) @(negedge clk);
    chk(!ras_n && cas_n, "R6 row held low while idle", {ras_n, cas_n}, 2'b01);
    access(12'h1AB, 1'b0, '0, 1'b0, lat, rd);
    chk(lat == 2, "R5 page hit from open row", 32'(lat), 2);
    chk(rd == (16'h01AB ^ 16'h3C3C), "R5 page hit data", 32'(rd), 32'(16'h01AB ^ 16'h3C3C));
    wr_cfg(8'h40);
    repeat (6) @(negedge clk);
    chk(ras_n, "R6 row closed when hold bit cleared", 32'(ras_n), 1);

    // bursts on, hold off (R6)
    access(12'h300, 1'b0, '0, 1'b0, lat, rd);
    repeat (6) @(negedge clk);
    chk(ras_n, "R6 RAS up mode releases row", 32'(ras_n), 1);

    // refresh has priority, CBR timing (R9, R8)
    wr_cfg(8'h93);
    repeat (6) @(negedge clk);
    clr_counts();
    access(12'h456, 1'b0, '0, 1'b1, lat, rd);
    chk(lat == 12, "R9 refresh before request", 32'(lat), 12);
    chk(rd == (16'h0456 ^ 16'h3C3C), "R9 data after refresh", 32'(rd), 32'(16'h0456 ^ 16'h3C3C));
    chk(cbr_cnt == 1, "R8 one CBR cycle", 32'(cbr_cnt), 1);
    chk(lead_cnt == 2, "R8 CAS lead with bit4", 32'(lead_cnt), 2);
    chk(rlow_cnt == 4, "R8 RAS low with 3 waits", 32'(rlow_cnt), 4);

    wr_cfg(8'h00);
    repeat (6) @(negedge clk);
    clr_counts();
    rfsh_tick = 1'b1;
    @(negedge clk);
    rfsh_tick = 1'b0;
    repeat (10) @(negedge clk);
    chk(lead_cnt == 1 && rlow_cnt == 1 && cbr_cnt == 1, "R8 minimal refresh",
        {8'(cbr_cnt), 8'(lead_cnt), 8'(rlow_cnt)}, 24'h010101);

    // pending refresh closes open row (R9)
    wr_cfg(8'h60);
    repeat (4) @(negedge clk);
    access(12'h123, 1'b1, 16'h1111, 1'b0, lat, rd);
    repeat (4) @(negedge clk);
    chk(!ras_n, "R9 row open before refresh", 32'(ras_n), 0);
    clr_counts();
    rfsh_tick = 1'b1;
    @(negedge clk);
    rfsh_tick = 1'b0;
    repeat (10) @(negedge clk);
    chk(cbr_cnt == 1 && ras_n, "R9 refresh closed the row", {8'(cbr_cnt), 8'(ras_n)}, 16'h0101);
    access(12'h150, 1'b0, '0, 1'b0, lat, rd);
    chk(lat == 3, "R9 next access starts from idle", 32'(lat), 3);
    wr_cfg(8'h00);
    repeat (6) @(negedge clk);

    // manual reset keeps register, standby clears it (R2, R1)
    wr_cfg(8'hA5);
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    @(negedge clk);
    chk(cfg_rdata == 8'hA5, "R2 manual reset keeps register", 32'(cfg_rdata), 32'h A5);
    chk(ras_n && cas_n, "R2 idle after manual reset", {ras_n, cas_n}, 2'b11);
    hw_stby = 1'b1;
    @(negedge clk);
    hw_stby = 1'b0;
    cur_cfg = 8'h00;
    chk(cfg_rdata == 8'h00, "R1 standby clears register", 32'(cfg_rdata), 0);

    finish_run();
  end

endmodule